// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block gives a processor 24 general-purpose external lines, arranged as three 8-bit ports named A, B and C. The processor reaches it through a small register window: an 8-bit data path (split here into a write path, a read path and a read-drive enable), two address bits, a chip select and separate read and write strobes. A configuration register, written at the fourth address, decides for each port whether its lines are inputs or outputs. It also decides whether ports A and B work as plain latched ports or as handshaken ports.

In plain mode every port is a simple latch toward the pins, or a window onto the pins. Port C is split into two 4-bit halves with their own direction bits. In strobed mode a port moves data under a handshake that uses lines borrowed from port C. An output port signals "data ready" and waits for an acknowledge. An input port captures the pins on a strobe and flags "buffer full". Either kind can raise an interrupt request once the exchange completes. A second form of configuration write, with the top bit clear, sets or clears a single port C bit. The same write also turns the interrupt enables of the handshake channels on and off.

Top module: `pp_top`

## Requirements
- R1: After synchronous reset the configuration reads 0x9B (every port a plain input), no line is driven (all output enables 0), all output latches are 0 and the read-drive enable is low.
- R2: An access happens only when cs is high together with exactly one of rd or wr. A write with cs low leaves every latch and pin unchanged. A read with cs low does not raise dout_en.
- R3: Address 00 selects port A, 01 port B, 10 port C and 11 the configuration register. A read returns its data on dout with dout_en high in the cycle after the read cycle. Reading address 11 returns the last configuration word written.
- R4: A configuration word has bit 7 = 1. Bit 4 sets the direction of port A and bit 1 the direction of port B, with 1 meaning input. An output port drives its latch with all enables high. Reading an output port returns its latch. Reading a plain input port returns the pins.
- R5: Bit 3 sets the direction of port C lines 7..4 and bit 0 the direction of lines 3..0, with 1 meaning input. A read of port C returns the latch for output halves and the pins for input halves.
- R6: Writing a configuration word clears the A, B and C output latches and all handshake state: ready lines go inactive, buffer-full flags, interrupt requests and interrupt enables go to 0.
- R7: A write to address 11 with bit 7 = 0 writes bit 0 into port C latch bit n, where n = bits 3..1. It leaves the configuration unchanged.
- R8: With bit 5 = 1 and port A output, C7 is an active-low ready output, C6 the active-low acknowledge input and C3 the interrupt output. A write to A drives C7 low and clears C3. A falling edge on C6 returns C7 high. The following rising edge on C6 sets C3 only while the A interrupt enable is 1. That enable is written by a bit-set/reset word with n = 6.
- R9: With bit 5 = 1 and port A input, C4 is an active-low strobe input, C5 a buffer-full output and C3 the interrupt output. A falling edge on C4 captures the A pins and sets C5. A rising edge on C4 sets C3 when the enable (n = 4) is 1 and the buffer is full. A read of A returns the captured byte and clears C5 and C3.
- R10: With bit 2 = 1, port B handshakes on C2 (acknowledge or strobe input), C1 (ready output, active low, or buffer-full output) and C0 (interrupt). Its rules match R8/R9, and its enable uses n = 2.
- R11: While a channel is strobed, a read of port C returns at its handshake output positions the values driven there, and at its handshake input position the channel's interrupt enable. Handshake inputs are never driven, and handshake outputs are always driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs | input | 1 | Chip select, active high |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| addr | input | 2 | Register select |
| din | input | 8 | Write data from processor |
| dout | output | 8 | Registered read data |
| dout_en | output | 1 | High when dout should drive the processor bus |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A drive values |
| pa_oe | output | 8 | Port A per-line drive enable |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B drive values |
| pb_oe | output | 8 | Port B per-line drive enable |
| pc_in | input | 8 | Port C pin values |
| pc_out | output | 8 | Port C drive values |
| pc_oe | output | 8 | Port C per-line drive enable |

## Verification
A corrupt configuration register shows at once on the enable outputs, and on the next configuration read. A lost or stuck handshake flag shows on the borrowed port C lines in the cycle after the strobe, acknowledge, port write or port read that should have moved it. A wrong interrupt enable shows in the next port C read, and on C3/C0 one cycle after the closing edge of an exchange. Latches that fail to clear on a configuration write show on the port outputs in the cycle after that write.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int PORT_W = 8;
  localparam int NCHAN  = 2;
  localparam int NSEL   = 4;
  localparam int AW     = $clog2(NSEL);
  localparam int CIW    = $clog2(PORT_W);

  typedef enum logic [AW-1:0] {
    SEL_A   = 2'b00,
    SEL_B   = 2'b01,
    SEL_C   = 2'b10,
    SEL_CFG = 2'b11
  } port_sel_e;

  // configuration word, msb first
  typedef struct packed {
    logic is_cfg;
    logic spare;
    logic a_strb;
    logic a_in;
    logic cu_in;
    logic b_strb;
    logic b_in;
    logic cl_in;
  } cfg_t;

  localparam logic [7:0] CFG_RESET = 8'h9B;

  // handshake line positions on port C, channel 0 = A, 1 = B
  function automatic logic [CIW-1:0] irq_pos(input int ch);
    return (ch == 0) ? CIW'(3) : CIW'(0);
  endfunction

  function automatic logic [CIW-1:0] flag_pos(input int ch, input logic is_in);
    if (ch == 0) return is_in ? CIW'(5) : CIW'(7);
    return CIW'(1);
  endfunction

  function automatic logic [CIW-1:0] hs_pos(input int ch, input logic is_in);
    if (ch == 0) return is_in ? CIW'(4) : CIW'(6);
    return CIW'(2);
  endfunction
endpackage

// File: rtl/pp_bus_dec.sv
module pp_bus_dec #(
  parameter int NS = 4,
  localparam int SW = $clog2(NS)
) (
  input  logic          cs,
  input  logic          rd,
  input  logic          wr,
  input  logic [SW-1:0] addr,
  output logic [NS-1:0] wr_sel,
  output logic [NS-1:0] rd_sel
);
  logic do_wr;
  logic do_rd;

  assign do_wr = cs & wr & ~rd;
  assign do_rd = cs & rd & ~wr;

  for (genvar i = 0; i < NS; i++) begin : g_sel
    assign wr_sel[i] = do_wr && (addr == SW'(i));
    assign rd_sel[i] = do_rd && (addr == SW'(i));
  end
endmodule

// File: rtl/pp_regs.sv
module pp_regs
  import pp_pkg::*;
#(
  parameter int PW = PORT_W,
  localparam int IW = $clog2(PW)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSEL-1:0] wr_sel,
  input  logic [PW-1:0]   din,
  output cfg_t            cfg,
  output logic [PW-1:0]   lat_a,
  output logic [PW-1:0]   lat_b,
  output logic [PW-1:0]   lat_c,
  output logic            cfg_wr,
  output logic            bit_wr,
  output logic [IW-1:0]   bit_idx,
  output logic            bit_val
);
  assign cfg_wr  = wr_sel[SEL_CFG] & din[7];
  assign bit_wr  = wr_sel[SEL_CFG] & ~din[7];
  assign bit_idx = din[IW:1];
  assign bit_val = din[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg   <= cfg_t'(CFG_RESET);
      lat_a <= '0;
      lat_b <= '0;
      lat_c <= '0;
    end else if (cfg_wr) begin
      cfg   <= cfg_t'(din[7:0]);
      lat_a <= '0;
      lat_b <= '0;
      lat_c <= '0;
    end else begin
      if (wr_sel[SEL_A]) lat_a <= din;
      if (wr_sel[SEL_B]) lat_b <= din;
      if (wr_sel[SEL_C]) lat_c <= din;
      if (bit_wr) lat_c[bit_idx] <= bit_val;
    end
  end
endmodule

// File: rtl/pp_hs_chan.sv
module pp_hs_chan #(
  parameter int PW = 8,
  parameter int IW = 3,
  parameter logic [IW-1:0] HS_IN_POS  = 4,
  parameter logic [IW-1:0] HS_OUT_POS = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic          is_in,
  input  logic          hs_n,
  input  logic          port_wr,
  input  logic          port_rd,
  input  logic [PW-1:0] pins,
  input  logic          bit_wr,
  input  logic [IW-1:0] bit_idx,
  input  logic          bit_val,
  output logic [PW-1:0] in_lat,
  output logic          busy,
  output logic          irq,
  output logic          inte
);
  logic          hs_prev;
  logic          fall;
  logic          rise;
  logic [IW-1:0] my_hs;

  assign my_hs = is_in ? HS_IN_POS : HS_OUT_POS;
  assign fall  = hs_prev & ~hs_n;
  assign rise  = ~hs_prev & hs_n;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      hs_prev <= 1'b1;
      busy    <= 1'b0;
      irq     <= 1'b0;
      inte    <= 1'b0;
      in_lat  <= '0;
    end else begin
      hs_prev <= hs_n;
      if (en) begin
        if (bit_wr && (bit_idx == my_hs)) inte <= bit_val;
        if (is_in) begin
          // capture wins over a same-cycle read so no byte is lost
          if (fall) begin
            in_lat <= pins;
            busy   <= 1'b1;
          end else if (port_rd) begin
            busy <= 1'b0;
          end
          if (port_rd) irq <= 1'b0;
          else if (rise && inte && busy) irq <= 1'b1;
        end else begin
          if (port_wr) begin
            busy <= 1'b1;
            irq  <= 1'b0;
          end else begin
            if (fall) busy <= 1'b0;
            if (rise && inte) irq <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pp_top.sv
module pp_top
  import pp_pkg::*;
#(
  parameter int PW = PORT_W,
  localparam int IW = $clog2(PW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs,
  input  logic          rd,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [PW-1:0] din,
  output logic [PW-1:0] dout,
  output logic          dout_en,
  input  logic [PW-1:0] pa_in,
  output logic [PW-1:0] pa_out,
  output logic [PW-1:0] pa_oe,
  input  logic [PW-1:0] pb_in,
  output logic [PW-1:0] pb_out,
  output logic [PW-1:0] pb_oe,
  input  logic [PW-1:0] pc_in,
  output logic [PW-1:0] pc_out,
  output logic [PW-1:0] pc_oe
);
  localparam int HALF = PW / 2;

  logic [NSEL-1:0] wr_sel;
  logic [NSEL-1:0] rd_sel;
  cfg_t            cfg_q;
  logic [PW-1:0]   lat_a;
  logic [PW-1:0]   lat_b;
  logic [PW-1:0]   lat_c;
  logic            cfg_wr;
  logic            bit_wr;
  logic [IW-1:0]   bit_idx;
  logic            bit_val;

  logic [NCHAN-1:0] ch_en;
  logic [NCHAN-1:0] ch_is_in;
  logic [NCHAN-1:0] ch_busy;
  logic [NCHAN-1:0] ch_irq;
  logic [NCHAN-1:0] ch_inte;
  logic [NCHAN-1:0] hs_n;
  logic [PW-1:0]    ch_pins [NCHAN];
  logic [PW-1:0]    ch_lat  [NCHAN];

  logic [PW-1:0] c_own_o;
  logic [PW-1:0] c_own_i;
  logic [PW-1:0] c_hs;
  logic [PW-1:0] c_half_out;
  logic [PW-1:0] a_rd;
  logic [PW-1:0] b_rd;
  logic [PW-1:0] c_rd;
  logic [PW-1:0] rd_mux;

  pp_bus_dec #(.NS(NSEL)) u_dec (
    .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wr_sel(wr_sel), .rd_sel(rd_sel)
  );

  pp_regs #(.PW(PW)) u_regs (
    .clk(clk), .rst(rst), .wr_sel(wr_sel), .din(din),
    .cfg(cfg_q), .lat_a(lat_a), .lat_b(lat_b), .lat_c(lat_c),
    .cfg_wr(cfg_wr), .bit_wr(bit_wr), .bit_idx(bit_idx), .bit_val(bit_val)
  );

  assign ch_en    = {cfg_q.b_strb, cfg_q.a_strb};
  assign ch_is_in = {cfg_q.b_in, cfg_q.a_in};
  assign ch_pins[0] = pa_in;
  assign ch_pins[1] = pb_in;

  for (genvar ch = 0; ch < NCHAN; ch++) begin : g_chan
    localparam logic [IW-1:0] HSI = IW'(hs_pos(ch, 1'b1));
    localparam logic [IW-1:0] HSO = IW'(hs_pos(ch, 1'b0));

    assign hs_n[ch] = ch_is_in[ch] ? pc_in[HSI] : pc_in[HSO];

    pp_hs_chan #(.PW(PW), .IW(IW), .HS_IN_POS(HSI), .HS_OUT_POS(HSO)) u_chan (
      .clk(clk), .rst(rst), .clr(cfg_wr),
      .en(ch_en[ch]), .is_in(ch_is_in[ch]), .hs_n(hs_n[ch]),
      .port_wr(wr_sel[ch]), .port_rd(rd_sel[ch]), .pins(ch_pins[ch]),
      .bit_wr(bit_wr), .bit_idx(bit_idx), .bit_val(bit_val),
      .in_lat(ch_lat[ch]), .busy(ch_busy[ch]), .irq(ch_irq[ch]), .inte(ch_inte[ch])
    );
  end

  // lines of port C borrowed by active handshake channels
  always_comb begin
    c_own_o = '0;
    c_own_i = '0;
    c_hs    = '0;
    for (int ch = 0; ch < NCHAN; ch++) begin
      if (ch_en[ch]) begin
        c_own_o[irq_pos(ch)] = 1'b1;
        c_hs[irq_pos(ch)]    = ch_irq[ch];
        c_own_o[flag_pos(ch, ch_is_in[ch])] = 1'b1;
        c_hs[flag_pos(ch, ch_is_in[ch])]    = ch_is_in[ch] ? ch_busy[ch] : ~ch_busy[ch];
        c_own_i[hs_pos(ch, ch_is_in[ch])]   = 1'b1;
        c_hs[hs_pos(ch, ch_is_in[ch])]      = ch_inte[ch];
      end
    end
  end

  assign c_half_out = {{HALF{~cfg_q.cu_in}}, {(PW - HALF){~cfg_q.cl_in}}};

  assign pa_out = lat_a;
  assign pa_oe  = {PW{~cfg_q.a_in}};
  assign pb_out = lat_b;
  assign pb_oe  = {PW{~cfg_q.b_in}};
  assign pc_oe  = c_own_o | (c_half_out & ~c_own_i);
  assign pc_out = (c_own_o & c_hs) | (~c_own_o & lat_c);

  assign a_rd = ~cfg_q.a_in ? lat_a : (cfg_q.a_strb ? ch_lat[0] : pa_in);
  assign b_rd = ~cfg_q.b_in ? lat_b : (cfg_q.b_strb ? ch_lat[1] : pb_in);
  assign c_rd = ((c_own_o | c_own_i) & c_hs)
              | (~(c_own_o | c_own_i) & ((c_half_out & lat_c) | (~c_half_out & pc_in)));

  always_comb begin
    rd_mux = '0;
    if (rd_sel[SEL_A])   rd_mux = a_rd;
    if (rd_sel[SEL_B])   rd_mux = b_rd;
    if (rd_sel[SEL_C])   rd_mux = c_rd;
    if (rd_sel[SEL_CFG]) rd_mux = PW'(cfg_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= '0;
      dout_en <= 1'b0;
    end else begin
      dout_en <= |rd_sel;
      if (|rd_sel) dout <= rd_mux;
    end
  end
endmodule

// File: rtl/pp_top_chk.sv
module pp_top_chk #(
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          cs,
  input logic          rd,
  input logic          wr,
  input logic [1:0]    addr,
  input logic          mode_bit,
  input logic          a_stb_n,
  input logic          a_strb,
  input logic          a_in,
  input logic          b_strb,
  input logic          b_in,
  input logic          dout_en,
  input logic [PW-1:0] pa_out,
  input logic [PW-1:0] pb_out,
  input logic [PW-1:0] pa_oe,
  input logic [PW-1:0] pb_oe,
  input logic [PW-1:0] pc_oe,
  input logic          rdy_a_n,
  input logic          ibf_a,
  input logic          irq_a,
  input logic          rdy_b_n
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pa_oe == '0 && pb_oe == '0 && pc_oe == '0 && pa_out == '0 && !dout_en));

  // R2
  no_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !(cs && rd) |=> !dout_en);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cs |=> ($stable(pa_out) && $stable(pb_out)));

  // R6
  cfg_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (cs && wr && !rd && addr == 2'b11 && mode_bit) |=> (pa_out == '0 && pb_out == '0));

  // R8
  rdy_a_chk: assert property (@(posedge clk) disable iff (rst)
    (cs && wr && !rd && addr == 2'b00 && a_strb && !a_in) |=> (!rdy_a_n && !irq_a));

  // R9
  ibf_a_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (cs && rd && !wr && addr == 2'b00 && a_strb && a_in && a_stb_n) |=> (!ibf_a && !irq_a));

  // R10
  rdy_b_chk: assert property (@(posedge clk) disable iff (rst)
    (cs && wr && !rd && addr == 2'b01 && b_strb && !b_in) |=> !rdy_b_n);
endmodule

bind pp_top pp_top_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
  .mode_bit(din[7]), .a_stb_n(pc_in[4]),
  .a_strb(cfg_q.a_strb), .a_in(cfg_q.a_in), .b_strb(cfg_q.b_strb), .b_in(cfg_q.b_in),
  .dout_en(dout_en), .pa_out(pa_out), .pb_out(pb_out),
  .pa_oe(pa_oe), .pb_oe(pb_oe), .pc_oe(pc_oe),
  .rdy_a_n(pc_out[7]), .ibf_a(pc_out[5]), .irq_a(pc_out[3]), .rdy_b_n(pc_out[1])
);

// File: tb/test_pp_top.sv
`timescale 1ns/1ps
module test_pp_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs = 1'b0;
  logic       rd = 1'b0;
  logic       wr = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       dout_en;
  logic [7:0] pa_in = '0;
  logic [7:0] pa_out;
  logic [7:0] pa_oe;
  logic [7:0] pb_in = '0;
  logic [7:0] pb_out;
  logic [7:0] pb_oe;
  logic [7:0] pc_in = '0;
  logic [7:0] pc_out;
  logic [7:0] pc_oe;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] mon_e;
  string      mon_t;

  always #2 clk = ~clk;

  pp_top i_pp_top (
    .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .din(din), .dout(dout), .dout_en(dout_en),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // driver: each call starts and ends at a falling edge
  task automatic bus_wr(logic [1:0] a, logic [7:0] d, logic sel = 1'b1);
    cs = sel; wr = 1'b1; addr = a; din = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(logic [1:0] a, logic [7:0] e, string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    cs = 1'b1; rd = 1'b1; addr = a;
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
  endtask

  // monitor: pairs returned read data with expected items
  always @(negedge clk) begin
    if (dout_en) begin
      if (exp_q.size() == 0) begin
        n_chk++;
        n_err++;
        $display("FAIL R3: unexpected read data %02h expected none", dout);
      end else begin
        mon_e = exp_q.pop_front();
        mon_t = tag_q.pop_front();
        check(mon_t, dout, mon_e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 pa_oe", pa_oe, 8'h00);
    check("R1 pb_oe", pb_oe, 8'h00);
    check("R1 pc_oe", pc_oe, 8'h00);
    check("R1 dout_en", {7'd0, dout_en}, 8'h00);
    bus_rd(2'b11, 8'h9B, "R1 cfg after reset");

    // plain inputs
    pa_in = 8'h5A; pb_in = 8'hC3; pc_in = 8'h3C;
    bus_rd(2'b00, 8'h5A, "R4 read A pins");
    bus_rd(2'b01, 8'hC3, "R3 read B pins");
    bus_rd(2'b10, 8'h3C, "R5 read C pins");

    // all plain outputs
    bus_wr(2'b11, 8'h80);
    check("R4 pa_oe", pa_oe, 8'hFF);
    check("R4 pb_oe", pb_oe, 8'hFF);
    check("R5 pc_oe", pc_oe, 8'hFF);
    bus_wr(2'b00, 8'h11);
    bus_wr(2'b01, 8'h22);
    bus_wr(2'b10, 8'h33);
    check("R4 pa_out", pa_out, 8'h11);
    check("R4 pb_out", pb_out, 8'h22);
    check("R3 pc_out", pc_out, 8'h33);
    bus_rd(2'b00, 8'h11, "R4 read A latch");
    bus_rd(2'b01, 8'h22, "R4 read B latch");

    // no access without chip select
    bus_wr(2'b00, 8'h99, 1'b0);
    check("R2 pa_out held", pa_out, 8'h11);
    cs = 1'b0; rd = 1'b1; addr = 2'b00;
    @(negedge clk);
    rd = 1'b0;
    check("R2 no dout_en", {7'd0, dout_en}, 8'h00);

    // split port C, latch clear on configuration write
    bus_wr(2'b11, 8'h88);
    check("R5 pc_oe lower out", pc_oe, 8'h0F);
    check("R6 pa_out cleared", pa_out, 8'h00);
    check("R6 pc_out cleared", pc_out & 8'h0F, 8'h00);
    bus_rd(2'b10, 8'h30, "R5 read C mixed");
    bus_wr(2'b10, 8'h0A);
    bus_rd(2'b10, 8'h3A, "R5 read C after write");
    bus_wr(2'b11, 8'h81);
    check("R5 pc_oe upper out", pc_oe, 8'hF0);

    // single-bit writes
    bus_wr(2'b11, 8'h0F);
    check("R7 set C7", {7'd0, pc_out[7]}, 8'h01);
    bus_wr(2'b11, 8'h0E);
    check("R7 clear C7", {7'd0, pc_out[7]}, 8'h00);
    bus_wr(2'b11, 8'h09);
    bus_rd(2'b10, 8'h1C, "R7 read C after bit set");
    bus_rd(2'b11, 8'h81, "R7 cfg unchanged");

    // port A strobed output
    pc_in = 8'h40;
    bus_wr(2'b11, 8'hA1);
    check("R11 pc_oe strobed A out", pc_oe, 8'hB8);
    check("R8 ready idle", {7'd0, pc_out[7]}, 8'h01);
    bus_wr(2'b11, 8'h0D);
    bus_rd(2'b10, 8'hC0, "R11 read C inte A");
    bus_wr(2'b00, 8'h77);
    check("R8 pa_out", pa_out, 8'h77);
    check("R8 ready low", {7'd0, pc_out[7]}, 8'h00);
    pc_in[6] = 1'b0;
    @(negedge clk);
    check("R8 ready high after ack", {7'd0, pc_out[7]}, 8'h01);
    check("R8 no irq yet", {7'd0, pc_out[3]}, 8'h00);
    pc_in[6] = 1'b1;
    @(negedge clk);
    check("R8 irq after ack end", {7'd0, pc_out[3]}, 8'h01);
    bus_wr(2'b00, 8'h78);
    check("R8 irq cleared by write", {7'd0, pc_out[3]}, 8'h00);
    check("R8 ready low again", {7'd0, pc_out[7]}, 8'h00);
    bus_wr(2'b11, 8'h0C);
    pc_in[6] = 1'b0;
    @(negedge clk);
    pc_in[6] = 1'b1;
    @(negedge clk);
    check("R8 irq gated by enable", {7'd0, pc_out[3]}, 8'h00);
    bus_rd(2'b10, 8'h80, "R11 read C inte off");

    // port A strobed input
    pc_in = 8'h50;
    @(negedge clk);
    bus_wr(2'b11, 8'hB9);
    check("R11 pc_oe strobed A in", pc_oe, 8'h28);
    check("R9 buffer empty", {7'd0, pc_out[5]}, 8'h00);
    bus_wr(2'b11, 8'h09);
    pa_in = 8'hA5;
    pc_in[4] = 1'b0;
    @(negedge clk);
    check("R9 buffer full", {7'd0, pc_out[5]}, 8'h01);
    pa_in = 8'h00;
    pc_in[4] = 1'b1;
    @(negedge clk);
    check("R9 irq after strobe", {7'd0, pc_out[3]}, 8'h01);
    bus_rd(2'b00, 8'hA5, "R9 captured byte");
    check("R9 buffer cleared by read", {7'd0, pc_out[5]}, 8'h00);
    check("R9 irq cleared by read", {7'd0, pc_out[3]}, 8'h00);

    // port B strobed output
    pc_in = 8'h54;
    @(negedge clk);
    bus_wr(2'b11, 8'h84);
    check("R10 pc_oe strobed B out", pc_oe, 8'hFB);
    check("R10 ready idle", {7'd0, pc_out[1]}, 8'h01);
    bus_wr(2'b11, 8'h05);
    bus_wr(2'b01, 8'h3C);
    check("R10 pb_out", pb_out, 8'h3C);
    check("R10 ready low", {7'd0, pc_out[1]}, 8'h00);
    pc_in[2] = 1'b0;
    @(negedge clk);
    check("R10 ready high after ack", {7'd0, pc_out[1]}, 8'h01);
    pc_in[2] = 1'b1;
    @(negedge clk);
    check("R10 irq", {7'd0, pc_out[0]}, 8'h01);
    bus_rd(2'b10, 8'h07, "R11 read C strobed B");
    bus_wr(2'b11, 8'h84);
    check("R6 irq cleared by cfg", {7'd0, pc_out[0]}, 8'h00);
    check("R6 ready idle after cfg", {7'd0, pc_out[1]}, 8'h01);
    check("R6 pb_out cleared", pb_out, 8'h00);

    @(negedge clk);
    check("R3 all reads returned", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule